// File: doc/BRIEF.md
# Frame-Based Line AIS Detector

This block watches a serial line for an alarm indication signal, which is a line carrying all ones. It counts the zeros in each frame period of fixed length. A frame with very few zeros is called quiet, and a frame with more zeros is called noisy. The alarm output is raised after a run of consecutive quiet frames and dropped after a run of consecutive noisy frames. A single frame that disagrees with the current state breaks the run. The block only reports the alarm and takes no other action.

An external framer supplies a loss-of-alignment flag, and a mode input selects how that flag is used. In the qualified mode, a quiet frame counts toward raising the alarm only while alignment is lost. A raised alarm is also dropped at once when alignment returns. The frame position is kept by a free-running counter that advances only on bits marked valid by the bit-enable strobe.

Top module: `line_ais_detector`

## Requirements
- R1: Reset puts the alarm output low and places the frame position at the first bit of a frame.
- R2: A frame is 2928 accepted bits. A cycle with `bit_en` low neither advances the frame position nor counts a zero, whatever `bit_in` is.
- R3: A frame with five or fewer zeros (`bit_in` = 0) is quiet. A frame with six or more zeros is noisy, and this holds for any number of zeros up to the whole frame.
- R4: In basic mode (`qual_mode` = 0), with the alarm low, two consecutive quiet frames raise the alarm in the cycle after the last bit of the second frame.
- R5: With the alarm high, two consecutive noisy frames lower the alarm in the cycle after the last bit of the second frame. This rule applies in both modes.
- R6: A frame that disagrees with the current alarm state restarts the two-frame run. The frame after it then cannot change the alarm on its own.
- R7: In qualified mode (`qual_mode` = 1), a quiet frame counts toward raising the alarm only if `lof` is 1 when its last bit is accepted.
- R8: In qualified mode, while the alarm is high, `lof` = 0 lowers the alarm on the next clock edge, whatever the frame position.
- R9: The alarm changes only on the edge after a frame's last accepted bit, or under the condition in R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Marks `bit_in` as a valid line bit in this cycle |
| bit_in | input | 1 | Serial line data bit |
| lof | input | 1 | Loss of frame alignment from an external framer (1 = lost) |
| qual_mode | input | 1 | 1 selects alignment-qualified detection and recovery |
| alarm | output | 1 | Line AIS alarm level |

## Verification
The frames are fed with zero counts of 5, 6 and a full 2928. These show the exact quiet/noisy boundary and confirm that saturation still reads as noisy. The patterns quiet-noisy-quiet-quiet and noisy-quiet-noisy-noisy show that the run restarts and does not simply accumulate. Zeros sent while `bit_en` is low separate gated bits from counted ones. In qualified mode, quiet frames are sent with `lof` low and then high, and `lof` is dropped in the middle of a frame. This separates the alignment gate on raising from the immediate clear.

// File: rtl/line_ais_detector.sv
module line_ais_detector #(
  parameter int FRAME_BITS = 2928,
  parameter int MAX_ZEROS  = 5,
  parameter int PERSIST    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  input  logic lof,
  input  logic qual_mode,
  output logic alarm
);
  localparam int PW = $clog2(FRAME_BITS);
  localparam int ZW = $clog2(MAX_ZEROS + 2);
  localparam int SW = $clog2(PERSIST + 1);
  localparam logic [ZW-1:0] ZSAT = ZW'(MAX_ZEROS + 1);

  logic [PW-1:0] pos;
  logic [ZW-1:0] zcnt;
  logic [SW-1:0] streak;
  logic          alarm_q;

  wire           frame_end = bit_en && (pos == PW'(FRAME_BITS - 1));
  wire           is_zero   = bit_en && !bit_in;
  wire [ZW-1:0]  zsum      = (zcnt == ZSAT) ? zcnt : zcnt + ZW'(is_zero);
  wire           quiet     = zsum <= ZW'(MAX_ZEROS);
  wire           realign   = qual_mode && !lof;
  wire           toward    = alarm_q ? !quiet : (quiet && (!qual_mode || lof));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= '0;
      zcnt    <= '0;
      streak  <= '0;
      alarm_q <= 1'b0;
    end else begin
      if (bit_en) pos <= frame_end ? '0 : pos + 1'b1;
      zcnt <= frame_end ? '0 : zsum;
      if (alarm_q && realign) begin
        alarm_q <= 1'b0;
        streak  <= '0;
      end else if (frame_end) begin
        if (!toward) begin
          streak <= '0;
        end else if (streak == SW'(PERSIST - 1)) begin
          alarm_q <= !alarm_q;
          streak  <= '0;
        end else begin
          streak <= streak + 1'b1;
        end
      end
    end
  end

  assign alarm = alarm_q;
endmodule

module line_ais_detector_chk #(
  parameter int FRAME_BITS = 2928,
  parameter int MAX_ZEROS  = 5,
  parameter int PW = 12,
  parameter int ZW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          lof,
  input logic          qual_mode,
  input logic          alarm,
  input logic [PW-1:0] pos,
  input logic [ZW-1:0] zcnt
);
  wire at_end = bit_en && (pos == PW'(FRAME_BITS - 1));

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !alarm);
  a_r2_gated_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(pos));
  a_r2_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    pos < PW'(FRAME_BITS));
  a_r3_zero_sat: assert property (@(posedge clk) disable iff (!rst_n)
    zcnt <= ZW'(MAX_ZEROS + 1));
  a_r7_rise_needs_lof: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> ($past(!qual_mode) || $past(lof)));
  a_r8_realign_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_mode && !lof && alarm) |=> !alarm);
  a_r9_rise_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(at_end));
  a_r9_fall_timing: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm) |-> ($past(at_end) || $past(qual_mode && !lof)));
endmodule

bind line_ais_detector line_ais_detector_chk #(
  .FRAME_BITS(FRAME_BITS), .MAX_ZEROS(MAX_ZEROS), .PW(PW), .ZW(ZW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .lof(lof),
  .qual_mode(qual_mode), .alarm(alarm), .pos(pos), .zcnt(zcnt)
);

// File: tb/line_ais_detector_test.sv
module line_ais_detector_test;
  localparam int FB = 2928;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic bit_in = 1'b1;
  logic lof = 1'b0;
  logic qual_mode = 1'b0;
  logic alarm;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  line_ais_detector uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .lof(lof), .qual_mode(qual_mode), .alarm(alarm)
  );

  task automatic chk(input logic exp, input string req);
    checks++;
    if (alarm !== exp) begin
      fails++;
      $display("FAIL %s: alarm=%b expected %b at %0t", req, alarm, exp, $time);
    end
  endtask

  // Starts and ends at a negedge. gap = gated zero cycles at start.
  task automatic send_frame(input int nz, input int gap, input int drop_at);
    for (int g = 0; g < gap; g++) begin
      bit_en = 1'b0;
      bit_in = 1'b0;
      @(posedge clk);
      @(negedge clk);
    end
    for (int i = 0; i < FB; i++) begin
      if (drop_at >= 0 && i == drop_at + 1) chk(1'b0, "R8 realign clear");
      bit_en = 1'b1;
      bit_in = (i < nz) ? 1'b0 : 1'b1;
      if (i == drop_at) lof = 1'b0;
      @(posedge clk);
      @(negedge clk);
    end
    bit_en = 1'b0;
    bit_in = 1'b1;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(1'b0, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(1'b0, "R1 after release");
  endtask

  task automatic t_basic_assert;
    send_frame(5, 0, -1); chk(1'b0, "R4 one quiet frame");
    send_frame(5, 0, -1); chk(1'b1, "R4 two quiet frames");
  endtask

  task automatic t_boundary_clear;
    send_frame(6, 0, -1); chk(1'b1, "R5 one noisy frame");
    send_frame(5, 0, -1); chk(1'b1, "R6 quiet breaks run");
    send_frame(6, 0, -1); chk(1'b1, "R6 restarted run");
    send_frame(6, 0, -1); chk(1'b0, "R5 two noisy frames");
  endtask

  task automatic t_restart_and_sat;
    send_frame(5, 0, -1);  chk(1'b0, "R6 first quiet");
    send_frame(6, 0, -1);  chk(1'b0, "R6 noisy breaks run");
    send_frame(5, 0, -1);  chk(1'b0, "R6 quiet after break");
    send_frame(5, 0, -1);  chk(1'b1, "R4 consecutive quiet");
    send_frame(FB, 0, -1); chk(1'b1, "R3 all-zero frame one");
    send_frame(FB, 0, -1); chk(1'b0, "R3 saturated count is noisy");
  endtask

  task automatic t_gated;
    send_frame(5, 50, -1); chk(1'b0, "R2 gated zeros first");
    send_frame(5, 50, -1); chk(1'b1, "R2 gated zeros not counted");
    send_frame(6, 0, -1);  chk(1'b1, "R5 noisy one");
    send_frame(6, 0, -1);  chk(1'b0, "R5 noisy two");
  endtask

  task automatic t_qual_gate;
    qual_mode = 1'b1;
    lof = 1'b0;
    send_frame(0, 0, -1); chk(1'b0, "R7 aligned quiet one");
    send_frame(0, 0, -1); chk(1'b0, "R7 aligned quiet two");
    lof = 1'b1;
    send_frame(0, 0, -1); chk(1'b0, "R7 lost quiet one");
    send_frame(0, 0, -1); chk(1'b1, "R7 lost quiet two");
  endtask

  task automatic t_qual_drop;
    send_frame(0, 0, 1000);
    chk(1'b0, "R9 stays low at frame end");
    lof = 1'b1;
  endtask

  task automatic t_qual_recover;
    send_frame(0, 0, -1); chk(1'b0, "R7 regain one");
    send_frame(0, 0, -1); chk(1'b1, "R7 regain two");
    send_frame(6, 0, -1); chk(1'b1, "R5 qual noisy one");
    send_frame(6, 0, -1); chk(1'b0, "R5 qual noisy two");
  endtask

  initial begin
    t_reset();
    t_basic_assert();
    t_boundary_clear();
    t_restart_and_sat();
    t_gated();
    t_qual_gate();
    t_qual_drop();
    t_qual_recover();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule